// File: doc/BRIEF.md
# XOR Swizzle Bank Mapper

This block turns a linear shared-memory byte address into the physical address used by a memory of 32 banks, each 4 bytes wide, so that one 128-byte line covers every bank once. The swizzle is a separate step placed after the linear address has been formed. It XORs the 16-byte sector index inside a line with the index of the row inside an atom that is 8 rows tall. Three atom widths can be selected: 128, 64 and 32 bytes. A pass-through mode leaves the address untouched. A mode is only legal when the tile row length, given in bytes, is at least the atom width and a whole multiple of it. If it is not, the block raises an illegal flag and passes the address through unchanged.

Alongside the single-address mapper sits a conflict estimator. It takes eight lane addresses that are issued together and swizzles each of them with the current mode. It then reports how many serialized cycles the access needs and whether any bank is asked for two or more distinct words. The mapping is combinational. The conflict result is registered and appears one cycle after the request.

Top module: `swz_mapper`

## Requirements
- R1: With mode code 0 (pass-through), addrOut equals addrIn and illegal is 0 for any rowBytes.
- R2: With mode code 3 (128-byte atom) and a legal row length, addrOut[6:4] = addrIn[6:4] XOR addrIn[9:7].
- R3: With mode code 2 (64-byte atom) and a legal row length, addrOut[5:4] = addrIn[5:4] XOR addrIn[8:7], and addrOut[6] = addrIn[6].
- R4: With mode code 1 (32-byte atom) and a legal row length, addrOut[4] = addrIn[4] XOR addrIn[7], and addrOut[6:5] = addrIn[6:5].
- R5: In every mode, addrOut[3:0] and all bits from bit 7 upward equal the matching bits of addrIn.
- R6: For a nonzero mode, illegal is 1 when rowBytes is below the atom width (32, 64 or 128 for codes 1, 2, 3) or is not a multiple of it. The address then passes through unchanged.
- R7: For a request, resCycles is the largest count, over all banks, of the distinct 4-byte words the eight lanes ask for in that bank. The lanes are first mapped like addrIn under the same mode and rowBytes. The bank is physical bits [6:2] and the word is physical bits [31:2]. Identical words count once.
- R8: resConflict is 1 exactly when resCycles is greater than 1.
- R9: resValid is high in the cycle after accValid was high and low otherwise. resCycles and resConflict hold their values while no request arrives.
- R10: Eight lanes that read the same column of eight consecutive 128-byte rows take 1 cycle in the 128-byte mode (row length 128) and 8 cycles in pass-through mode.
- R11: After reset, resValid, resCycles and resConflict are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 pass-through, 1 32-byte atom, 2 64-byte atom, 3 128-byte atom |
| rowBytes | input | 16 | Tile row length in bytes, used for the legality check |
| addrIn | input | 32 | Linear byte address to map |
| addrOut | output | 32 | Swizzled physical byte address |
| illegal | output | 1 | Selected mode does not fit the row length |
| accValid | input | 1 | Eight-lane request strobe |
| laneAddr | input | 256 | Eight linear lane addresses, lane k in bits [32k+31:32k] |
| resValid | output | 1 | Conflict result valid, one cycle after accValid |
| resCycles | output | 4 | Serialized cycles needed by the request |
| resConflict | output | 1 | Some bank is asked for more than one word |

## Verification
The mapper is driven with random addresses under every mode, paired with row lengths drawn from a set that covers zero, too short, non-multiple and legal values. This separates the XOR placement of each atom width from the legality gate. The estimator gets column reads across eight rows, for which the 128-byte and pass-through modes must give 1 and 8 cycles, and all-identical addresses, which must give 1 cycle because duplicates count once. It also gets random lanes packed into a 1 KiB window, which produces a spread of partial conflicts. Idle cycles between requests show whether the registered result is held or overwritten.

// File: rtl/swz_pkg.sv
package swz_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_32   = 2'd1,
    MODE_64   = 2'd2,
    MODE_128  = 2'd3
  } swzMode_e;

  localparam int SECT_LSB = 4;
  localparam int SECT_W   = 3;
  localparam int BANK_LSB = 2;
  localparam int BANK_W   = 5;
  localparam int ROW_W    = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic       legal;
    logic [2:0] sectMask;
    logic [3:0] rowLsb;
    logic [1:0] rowDown;
  } swzCtl_t;
endpackage

// File: rtl/swz_ctrl.sv
module swz_ctrl
  import swz_pkg::*;
#(
  parameter int ROWB_W = 16
) (
  input  logic [1:0]        mode,
  input  logic [ROWB_W-1:0] rowBytes,
  output swzCtl_t           ctl,
  output logic              illegal
);
  localparam int EXT_W = ROWB_W + 1;

  logic [EXT_W-1:0] atomBytes;
  logic [EXT_W-1:0] rowExt;
  logic [3:0]       rowLsbSel;
  logic [1:0]       rowDownSel;
  logic [2:0]       maskSel;
  logic             fits;

  always_comb begin
    rowLsbSel  = 4'd7;
    rowDownSel = 2'd0;
    maskSel    = 3'b000;
    atomBytes  = '0;
    case (swzMode_e'(mode))
      MODE_32: begin
        rowLsbSel = 4'd5; rowDownSel = 2'd2; maskSel = 3'b001;
        atomBytes = EXT_W'(32);
      end
      MODE_64: begin
        rowLsbSel = 4'd6; rowDownSel = 2'd1; maskSel = 3'b011;
        atomBytes = EXT_W'(64);
      end
      MODE_128: begin
        rowLsbSel = 4'd7; rowDownSel = 2'd0; maskSel = 3'b111;
        atomBytes = EXT_W'(128);
      end
      default: begin
        rowLsbSel = 4'd7; rowDownSel = 2'd0; maskSel = 3'b000;
        atomBytes = '0;
      end
    endcase
  end

  assign rowExt = {1'b0, rowBytes};

  always_comb begin
    if (mode == 2'd0) fits = 1'b1;
    else fits = (rowExt >= atomBytes) && ((rowExt & (atomBytes - EXT_W'(1))) == '0);
  end

  assign illegal      = !fits;
  assign ctl.legal    = fits;
  assign ctl.sectMask = fits ? maskSel : 3'b000;
  assign ctl.rowLsb   = rowLsbSel;
  assign ctl.rowDown  = rowDownSel;
endmodule

// File: rtl/swz_remap.sv
module swz_remap
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  swzCtl_t           ctl,
  output logic [ADDR_W-1:0] phys
);
  logic [ADDR_W-1:0] shifted;
  logic [ROW_W-1:0]  rowIdx;
  logic [ROW_W-1:0]  rowAdj;
  logic [SECT_W-1:0] xorVal;

  always_comb begin
    shifted = addr >> ctl.rowLsb;
    rowIdx  = shifted[ROW_W-1:0];
    rowAdj  = rowIdx >> ctl.rowDown;
    xorVal  = rowAdj & ctl.sectMask;
    phys    = addr;
    phys[SECT_LSB +: SECT_W] = addr[SECT_LSB +: SECT_W] ^ xorVal;
  end
endmodule

// File: rtl/swz_conflict.sv
module swz_conflict
  import swz_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accValid,
  input  logic [LANES*ADDR_W-1:0] physFlat,
  output logic                    resValid,
  output logic [CNT_W-1:0]        resCycles,
  output logic                    resConflict
);
  localparam int WORD_W = ADDR_W - BANK_LSB;

  logic [BANK_W-1:0] bankOf [LANES];
  logic [WORD_W-1:0] wordOf [LANES];
  logic [LANES-1:0]  firstHit;
  logic [CNT_W-1:0]  maxCnt;

  for (genvar k = 0; k < LANES; k++) begin : g_split
    assign bankOf[k] = physFlat[k*ADDR_W + BANK_LSB +: BANK_W];
    assign wordOf[k] = physFlat[k*ADDR_W + BANK_LSB +: WORD_W];
  end

  // a lane is the first requester of its word when no lower lane asks for it
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      firstHit[i] = 1'b1;
      for (int j = 0; j < i; j++) begin
        if (wordOf[j] == wordOf[i]) firstHit[i] = 1'b0;
      end
    end
  end

  always_comb begin
    logic [CNT_W-1:0] cnt;
    maxCnt = '0;
    for (int i = 0; i < LANES; i++) begin
      cnt = '0;
      for (int j = 0; j < LANES; j++) begin
        if (firstHit[j] && bankOf[j] == bankOf[i]) cnt = cnt + CNT_W'(1);
      end
      if (cnt > maxCnt) maxCnt = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resValid    <= 1'b0;
      resCycles   <= '0;
      resConflict <= 1'b0;
    end else begin
      resValid <= accValid;
      if (accValid) begin
        resCycles   <= maxCnt;
        resConflict <= (maxCnt > CNT_W'(1));
      end
    end
  end
endmodule

// File: rtl/swz_mapper.sv
module swz_mapper
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8,
  parameter int ROWB_W = 16,
  parameter int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode,
  input  logic [ROWB_W-1:0]       rowBytes,
  input  logic [ADDR_W-1:0]       addrIn,
  output logic [ADDR_W-1:0]       addrOut,
  output logic                    illegal,
  input  logic                    accValid,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  output logic                    resValid,
  output logic [CNT_W-1:0]        resCycles,
  output logic                    resConflict
);
  swzCtl_t ctl;
  logic [LANES*ADDR_W-1:0] lanePhys;

  swz_ctrl #(.ROWB_W(ROWB_W)) u_ctrl (
    .mode(mode), .rowBytes(rowBytes), .ctl(ctl), .illegal(illegal)
  );

  swz_remap #(.ADDR_W(ADDR_W)) u_main (
    .addr(addrIn), .ctl(ctl), .phys(addrOut)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    swz_remap #(.ADDR_W(ADDR_W)) u_lane (
      .addr(laneAddr[k*ADDR_W +: ADDR_W]),
      .ctl (ctl),
      .phys(lanePhys[k*ADDR_W +: ADDR_W])
    );
  end

  swz_conflict #(.LANES(LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_conf (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .physFlat(lanePhys),
    .resValid(resValid), .resCycles(resCycles), .resConflict(resConflict)
  );
endmodule

// File: rtl/swz_mapper_chk.sv
module swz_mapper_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 8,
  parameter int ROWB_W = 16,
  parameter int CNT_W  = $clog2(LANES + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              mode,
  input logic [ROWB_W-1:0]       rowBytes,
  input logic [ADDR_W-1:0]       addrIn,
  input logic [ADDR_W-1:0]       addrOut,
  input logic                    illegal,
  input logic                    accValid,
  input logic [LANES*ADDR_W-1:0] laneAddr,
  input logic                    resValid,
  input logic [CNT_W-1:0]        resCycles,
  input logic                    resConflict
);
  // R1
  none_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (addrOut == addrIn && !illegal));
  // R5
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addrOut[3:0] == addrIn[3:0]) && (addrOut[ADDR_W-1:7] == addrIn[ADDR_W-1:7]));
  // R2
  xor128_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !illegal) |-> (addrOut[6:4] == (addrIn[6:4] ^ addrIn[9:7])));
  // R6
  illegal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (addrOut == addrIn));
  // R6
  zero_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && rowBytes == '0) |-> illegal);
  // R9
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accValid |=> resValid);
  // R9
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accValid |=> !resValid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accValid |=> ($stable(resCycles) && $stable(resConflict)));
  // R7
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> (resCycles >= CNT_W'(1) && resCycles <= CNT_W'(LANES)));
  // R8
  conflict_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> (resConflict == (resCycles > CNT_W'(1))));
endmodule

bind swz_mapper swz_mapper_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .ROWB_W(ROWB_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/swz_mapper_bench.sv
module swz_mapper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = '0;
  logic [15:0]   rowBytes = '0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] addrOut;
  logic          illegal;
  logic          accValid = 1'b0;
  logic [NL*AW-1:0] laneAddr = '0;
  logic          resValid;
  logic [3:0]    resCycles;
  logic          resConflict;

  int nTests = 0;
  int nFails = 0;
  logic [AW-1:0] la [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  swz_mapper u_swz_mapper (.*);

  function automatic logic expIllegal(input logic [1:0] m, input logic [15:0] rb);
    int atom;
    atom = (m == 2'd1) ? 32 : (m == 2'd2) ? 64 : 128;
    if (m == 2'd0) return 1'b0;
    return (int'(rb) < atom) || ((int'(rb) % atom) != 0);
  endfunction

  function automatic logic [AW-1:0] expMap(input logic [AW-1:0] a, input logic [1:0] m,
                                           input logic [15:0] rb);
    logic [AW-1:0] r;
    r = a;
    if (expIllegal(m, rb)) return r;
    case (m)
      2'd3: r[6:4] = a[6:4] ^ a[9:7];
      2'd2: r[5:4] = a[5:4] ^ a[8:7];
      2'd1: r[4]   = a[4] ^ a[7];
      default: ;
    endcase
    return r;
  endfunction

  function automatic int expCycles(input logic [1:0] m, input logic [15:0] rb);
    logic [AW-1:0] p [NL];
    int best, c;
    bit first [NL];
    best = 0;
    for (int i = 0; i < NL; i++) p[i] = expMap(la[i], m, rb);
    for (int i = 0; i < NL; i++) begin
      first[i] = 1;
      for (int j = 0; j < i; j++) if (p[j][AW-1:2] == p[i][AW-1:2]) first[i] = 0;
    end
    for (int i = 0; i < NL; i++) begin
      c = 0;
      for (int j = 0; j < NL; j++) if (first[j] && p[j][6:2] == p[i][6:2]) c++;
      if (c > best) best = c;
    end
    return best;
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mapOne(input logic [AW-1:0] a, input logic [1:0] m, input logic [15:0] rb,
                        input string req);
    @(negedge clk);
    addrIn = a; mode = m; rowBytes = rb;
    #1;
    check(req, addrOut, expMap(a, m, rb));
    check("R6 illegal", AW'(illegal), AW'(expIllegal(m, rb)));
  endtask

  task automatic access(input logic [1:0] m, input logic [15:0] rb, input string req);
    int ec;
    ec = expCycles(m, rb);
    @(negedge clk);
    mode = m; rowBytes = rb; accValid = 1'b1;
    for (int k = 0; k < NL; k++) laneAddr[k*AW +: AW] = la[k];
    @(posedge clk); #1;
    check({req, " cycles"}, AW'(resCycles), AW'(ec));
    check("R8 conflict", AW'(resConflict), AW'(ec > 1));
    check("R9 valid", AW'(resValid), 1);
    @(negedge clk);
    accValid = 1'b0;
    laneAddr = '0;
    @(posedge clk); #1;
    check("R9 drop", AW'(resValid), 0);
    check("R9 hold", AW'(resCycles), AW'(ec));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin : main
    logic [15:0] rbSet [9];
    void'($urandom(32'd1234));
    rbSet = '{16'd0, 16'd16, 16'd32, 16'd48, 16'd64, 16'd96, 16'd128, 16'd192, 16'd256};
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset valid", AW'(resValid), 0);
    check("R11 reset cycles", AW'(resCycles), 0);
    check("R11 reset conflict", AW'(resConflict), 0);
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    mapOne(32'h0000_0380, 2'd3, 16'd128, "R2 row7 sector0");
    mapOne(32'h0000_0180, 2'd2, 16'd64,  "R3 row3");
    mapOne(32'h0000_0080, 2'd1, 16'd32,  "R4 row1");
    mapOne(32'hFFFF_FFFF, 2'd0, 16'd0,   "R1 passthrough");
    mapOne(32'h0000_0380, 2'd3, 16'd64,  "R6 short row");
    mapOne(32'h0000_0380, 2'd3, 16'd192, "R6 non-multiple");

    // random mapping
    for (int n = 0; n < 300; n++) begin
      logic [1:0] m;
      m = 2'($urandom);
      mapOne($urandom, m, rbSet[$urandom % 9],
             m == 2'd3 ? "R2/R5 random" : m == 2'd2 ? "R3/R5 random" :
             m == 2'd1 ? "R4/R5 random" : "R1 random");
    end

    // R10 column of eight 128-byte rows
    for (int k = 0; k < NL; k++) la[k] = 32'h1000 + 32'(k * 128) + 32'h14;
    access(2'd3, 16'd128, "R10 swizzled column");
    check("R10 swizzled column is 1", AW'(resCycles), 1);
    access(2'd0, 16'd128, "R10 plain column");
    check("R10 plain column is 8", AW'(resCycles), 8);

    // R7 identical addresses count once
    for (int k = 0; k < NL; k++) la[k] = 32'h2040;
    access(2'd0, 16'd0, "R7 identical");

    // R7 random lanes in a 1 KiB window
    for (int n = 0; n < 200; n++) begin
      logic [AW-1:0] base;
      base = {$urandom, 10'd0};
      for (int k = 0; k < NL; k++) la[k] = base + AW'($urandom % 1024);
      access(2'($urandom), rbSet[$urandom % 9], "R7 random");
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule